// File: doc/BRIEF.md
# Stream DMA Channel Control and Status Registers

This block is the software-visible register bank for one direction of a stream DMA channel. A simple register port writes and reads three 32-bit words: a control word, a status word and a base address. The control word carries the start bit, a two-bit transfer mode and two interrupt enables. When software moves the start bit from 0 to 1, the bank sends the transfer engine a start pulse one clock long. The base address and the mode go to the engine on plain outputs.

The engine reports back with a done pulse and three error pulses: internal failure, address decode failure and target failure. The status word holds these as sticky bits. It also holds two interrupt flags, one for errors and one for completion. A flag is set only when its enable bit is on, and software clears it by writing 1 to its bit. The block drives a single interrupt line, which is the OR of the two flags.

Top module: `dma_csr_bank`

## Requirements
- R1: After synchronous reset, all three registers read zero, and irq, start_pulse, mode and base_addr are 0.
- R2: The control word is at byte offset 0x00. It keeps bits 0 (start), 2 and 3 (mode, also driven on `mode`), 4 (error interrupt enable) and 5 (completion interrupt enable). Every other bit reads 0.
- R3: `start_pulse` is high for exactly one cycle. It is high in the cycle after a control write that takes bit 0 from 0 to 1. Writing 1 to bit 0 while it is already 1 gives no pulse.
- R4: A start edge clears the done bit and the error code in the same cycle as the pulse. It leaves both interrupt flags unchanged.
- R5: Status bit 0 (status word at byte offset 0x04) goes to 1 on an `eng_done` pulse and stays 1 until the next start edge.
- R6: Status bits 3:1 are sticky error bits. Bit 1 is internal, bit 2 is decode and bit 3 is slave. Each is set by its own engine input, and several may be 1 at the same time.
- R7: Status bit 4 is set on any error pulse only if control bit 4 is 1 in that cycle. Status bit 5 is set on `eng_done` only if control bit 5 is 1 in that cycle.
- R8: Writing 1 to status bit 4 or bit 5 clears that flag. Writing 0 to either has no effect. Writes to status bits 0 to 3 are ignored. If a flag is set and cleared in the same cycle, the set wins.
- R9: `irq` is 1 exactly when at least one of status bits 4 and 5 is 1, in the same cycle.
- R10: The base address word is at byte offset 0x08. It is fully writable and drives `base_addr`.
- R11: `rd_data` updates one cycle after `rd_en`. Any address other than 0x00, 0x04 or 0x08 reads zero, including unaligned addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| base_addr | output | 32 | Transfer base address to the engine |
| mode | output | 2 | Transfer mode bits to the engine |
| start_pulse | output | 1 | One-cycle start command to the engine |
| eng_done | input | 1 | Engine completion pulse |
| eng_err_internal | input | 1 | Engine internal failure pulse |
| eng_err_decode | input | 1 | Engine address decode failure pulse |
| eng_err_slave | input | 1 | Engine target failure pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default ADDR_W of 8, which fully decodes the byte addresses. With this width, unaligned and unmapped offsets such as 0x01 and 0x0C can be read and must return zero. Running the whole register map at its real offsets also shows that start edges, error combinations, write-one-to-clear and the enable gating at event time all act on the right bits.

// File: rtl/dcsr_pkg.sv
package dcsr_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned NUM_ERR = 3;

  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_STAT = 4;
  localparam int unsigned OFS_BASE = 8;

  localparam int unsigned CB_START  = 0;
  localparam int unsigned CB_MODE   = 2;
  localparam int unsigned MODE_W    = 2;
  localparam int unsigned CB_ERR_EN = 4;
  localparam int unsigned CB_CMP_EN = 5;

  localparam int unsigned SB_DONE    = 0;
  localparam int unsigned SB_ERR     = 1;
  localparam int unsigned SB_IRQ_ERR = 4;
  localparam int unsigned SB_IRQ_CMP = 5;

  localparam logic [WORD_W-1:0] CTRL_MASK = 32'h0000_003D;

  // err[0] internal, err[1] decode, err[2] slave
  typedef struct packed {
    logic               done;
    logic [NUM_ERR-1:0] err;
  } eng_evt_t;
endpackage

// File: rtl/dcsr_ctrl.sv
module dcsr_ctrl
  import dcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] ctrl_q,
  output logic              start_trig,
  output logic              start_pulse
);
  assign start_trig = wr_sel && wr_data[CB_START] && !ctrl_q[CB_START];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= '0;
      start_pulse <= 1'b0;
    end else begin
      start_pulse <= start_trig;
      if (wr_sel) ctrl_q <= wr_data & CTRL_MASK;
    end
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> !start_pulse); // R3
  AST_START_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> (ctrl_q[CB_START] && !$past(ctrl_q[CB_START]))); // R3
endmodule

// File: rtl/dcsr_status.sv
module dcsr_status
  import dcsr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start_trig,
  input  logic               clr_sel,
  input  logic [WORD_W-1:0]  clr_data,
  input  eng_evt_t           evt,
  input  logic               err_en,
  input  logic               cmp_en,
  output logic               done_q,
  output logic [NUM_ERR-1:0] err_q,
  output logic               flag_err_q,
  output logic               flag_cmp_q,
  output logic               irq
);
  logic evt_done, evt_err;
  logic set_ferr, set_fcmp, clr_ferr, clr_fcmp;
  logic ferr_n, fcmp_n, done_n;

  always_comb begin
    evt_done = evt.done;
    evt_err  = |evt.err;
    set_ferr = evt_err && err_en;
    set_fcmp = evt_done && cmp_en;
    clr_ferr = clr_sel && clr_data[SB_IRQ_ERR];
    clr_fcmp = clr_sel && clr_data[SB_IRQ_CMP];
    // a new event beats both the start clear and the software clear
    done_n   = (done_q && !start_trig) || evt_done;
    ferr_n   = (flag_err_q && !clr_ferr) || set_ferr;
    fcmp_n   = (flag_cmp_q && !clr_fcmp) || set_fcmp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q     <= 1'b0;
      flag_err_q <= 1'b0;
      flag_cmp_q <= 1'b0;
      irq        <= 1'b0;
    end else begin
      done_q     <= done_n;
      flag_err_q <= ferr_n;
      flag_cmp_q <= fcmp_n;
      irq        <= ferr_n || fcmp_n;
    end
  end

  for (genvar g = 0; g < NUM_ERR; g++) begin : g_err
    always_ff @(posedge clk) begin
      if (rst) err_q[g] <= 1'b0;
      else     err_q[g] <= (err_q[g] && !start_trig) || evt.err[g];
    end
  end

  AST_CMP_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_cmp_q) |-> $past(cmp_en)); // R7
  AST_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_err_q) |-> $past(err_en)); // R7
  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
    ($past(start_trig) && !$past(evt_done)) |-> !done_q); // R4
  AST_START_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    ($past(start_trig) && $past(flag_cmp_q) && !$past(clr_fcmp)) |-> flag_cmp_q); // R4
  AST_W1C_ERR: assert property (@(posedge clk) disable iff (rst)
    ($past(clr_ferr) && !$past(set_ferr)) |-> !flag_err_q); // R8
  AST_IRQ_IS_OR: assert property (@(posedge clk) disable iff (rst)
    irq == (flag_err_q || flag_cmp_q)); // R9
endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
  import dcsr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic [31:0]       base_addr,
  output logic [1:0]        mode,
  output logic              start_pulse,
  input  logic              eng_done,
  input  logic              eng_err_internal,
  input  logic              eng_err_decode,
  input  logic              eng_err_slave,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(OFS_BASE);

  logic               sel_ctrl, sel_stat, sel_base;
  logic [WORD_W-1:0]  ctrl_q, base_q, stat_word, rd_mux;
  logic               start_trig;
  logic               done_q, flag_err_q, flag_cmp_q;
  logic [NUM_ERR-1:0] err_q;
  eng_evt_t           evt;

  assign sel_ctrl = wr_en && (wr_addr == A_CTRL);
  assign sel_stat = wr_en && (wr_addr == A_STAT);
  assign sel_base = wr_en && (wr_addr == A_BASE);
  assign evt      = '{done: eng_done, err: {eng_err_slave, eng_err_decode, eng_err_internal}};

  dcsr_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_sel     (sel_ctrl),
    .wr_data    (wr_data),
    .ctrl_q     (ctrl_q),
    .start_trig (start_trig),
    .start_pulse(start_pulse)
  );

  dcsr_status u_stat (
    .clk       (clk),
    .rst       (rst),
    .start_trig(start_trig),
    .clr_sel   (sel_stat),
    .clr_data  (wr_data),
    .evt       (evt),
    .err_en    (ctrl_q[CB_ERR_EN]),
    .cmp_en    (ctrl_q[CB_CMP_EN]),
    .done_q    (done_q),
    .err_q     (err_q),
    .flag_err_q(flag_err_q),
    .flag_cmp_q(flag_cmp_q),
    .irq       (irq)
  );

  always_ff @(posedge clk) begin
    if (rst)           base_q <= '0;
    else if (sel_base) base_q <= wr_data;
  end

  always_comb begin
    stat_word                           = '0;
    stat_word[SB_DONE]                  = done_q;
    stat_word[SB_ERR +: NUM_ERR]        = err_q;
    stat_word[SB_IRQ_ERR]               = flag_err_q;
    stat_word[SB_IRQ_CMP]               = flag_cmp_q;
    case (rd_addr)
      A_CTRL:  rd_mux = ctrl_q;
      A_STAT:  rd_mux = stat_word;
      A_BASE:  rd_mux = base_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  assign base_addr = base_q;
  assign mode      = ctrl_q[CB_MODE +: MODE_W];

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr != A_CTRL && rd_addr != A_STAT && rd_addr != A_BASE)
      |=> rd_data == '0); // R11
  AST_BASE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !$past(sel_base) |-> $stable(base_addr)); // R10
endmodule

// File: tb/sim_dma_csr_bank.sv
`timescale 1ns/1ps
module sim_dma_csr_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, base_addr;
  logic [1:0]  mode;
  logic        start_pulse, irq;
  logic        eng_done = 1'b0, eng_err_internal = 1'b0;
  logic        eng_err_decode = 1'b0, eng_err_slave = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dma_csr_bank #(.ADDR_W(8)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .base_addr(base_addr),
    .mode(mode), .start_pulse(start_pulse), .eng_done(eng_done),
    .eng_err_internal(eng_err_internal), .eng_err_decode(eng_err_decode),
    .eng_err_slave(eng_err_slave), .irq(irq)
  );

  // row: {op[7:0], req[7:0], addr[7:0], data[31:0], exp[31:0]}
  // op 0 write, 1 read and compare, 2 engine event (data bit0 done, 1 internal, 2 decode, 3 slave)
  localparam int NV = 24;
  localparam logic [87:0] VEC [NV] = '{
    {8'd1, 8'd1,  8'h00, 32'h0,         32'h0},         // R1
    {8'd1, 8'd1,  8'h04, 32'h0,         32'h0},         // R1
    {8'd1, 8'd1,  8'h08, 32'h0,         32'h0},         // R1
    {8'd0, 8'd10, 8'h08, 32'hA5A5_0004, 32'h0},
    {8'd1, 8'd10, 8'h08, 32'h0,         32'hA5A5_0004}, // R10
    {8'd0, 8'd2,  8'h00, 32'hFFFF_FFFE, 32'h0},
    {8'd1, 8'd2,  8'h00, 32'h0,         32'h0000_003C}, // R2
    {8'd0, 8'd2,  8'h00, 32'h0000_003D, 32'h0},
    {8'd1, 8'd2,  8'h00, 32'h0,         32'h0000_003D}, // R2
    {8'd2, 8'd5,  8'h00, 32'h3,         32'h0},
    {8'd1, 8'd5,  8'h04, 32'h0,         32'h0000_0033}, // R5 R6 R7
    {8'd0, 8'd8,  8'h04, 32'h0000_000F, 32'h0},
    {8'd1, 8'd8,  8'h04, 32'h0,         32'h0000_0033}, // R8 low bits ignored
    {8'd0, 8'd8,  8'h04, 32'h0000_0010, 32'h0},
    {8'd1, 8'd8,  8'h04, 32'h0,         32'h0000_0023}, // R8 one flag cleared
    {8'd0, 8'd4,  8'h00, 32'h0000_003C, 32'h0},
    {8'd0, 8'd4,  8'h00, 32'h0000_003D, 32'h0},
    {8'd1, 8'd4,  8'h04, 32'h0,         32'h0000_0020}, // R4
    {8'd2, 8'd6,  8'h00, 32'hC,         32'h0},
    {8'd1, 8'd6,  8'h04, 32'h0,         32'h0000_003C}, // R6
    {8'd1, 8'd11, 8'h0C, 32'h0,         32'h0},         // R11
    {8'd1, 8'd11, 8'h01, 32'h0,         32'h0},         // R11
    {8'd0, 8'd8,  8'h04, 32'h0000_0030, 32'h0},
    {8'd1, 8'd8,  8'h04, 32'h0,         32'h0000_000C}  // R8
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic ev(input logic [3:0] e);
    {eng_err_slave, eng_err_decode, eng_err_internal, eng_done} = e;
    @(negedge clk);
    {eng_err_slave, eng_err_decode, eng_err_internal, eng_done} = '0;
  endtask

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 start_pulse", {31'b0, start_pulse}, 32'h0);
    chk("R1 mode", {30'b0, mode}, 32'h0);
    chk("R1 base_addr", base_addr, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][87:80])
        8'd0: wr(VEC[i][71:64], VEC[i][63:32]);
        8'd1: begin
          rd(VEC[i][71:64], v);
          chk($sformatf("R%0d row %0d", VEC[i][79:72], i), v, VEC[i][31:0]);
        end
        default: ev(VEC[i][35:32]);
      endcase
    end

    // R3: one-cycle pulse on a 0 to 1 edge only
    wr(8'h00, 32'h3C);
    chk("R3 no pulse on clear", {31'b0, start_pulse}, 32'h0);
    wr(8'h00, 32'h3D);
    chk("R3 pulse high", {31'b0, start_pulse}, 32'h1);
    @(negedge clk);
    chk("R3 pulse ends", {31'b0, start_pulse}, 32'h0);
    wr(8'h00, 32'h3D);
    chk("R3 no pulse when already set", {31'b0, start_pulse}, 32'h0);

    // R7 and R2: enables off, mode bits both set
    wr(8'h04, 32'h30);
    chk("R9 irq low after clear", {31'b0, irq}, 32'h0);
    wr(8'h00, 32'h0C);
    chk("R2 mode output", {30'b0, mode}, 32'h3);
    ev(4'h9);
    chk("R9 irq stays low without enable", {31'b0, irq}, 32'h0);
    rd(8'h04, v);
    chk("R7 no flags without enable", v, 32'h0000_0009);

    // R9: completion enable on, done raises irq in the same cycle as the flag
    wr(8'h00, 32'h20);
    ev(4'h1);
    chk("R9 irq on completion", {31'b0, irq}, 32'h1);
    wr(8'h04, 32'h00);
    chk("R8 writing zero keeps flag", {31'b0, irq}, 32'h1);
    wr(8'h04, 32'h20);
    chk("R9 irq after clear", {31'b0, irq}, 32'h0);
    chk("R10 base_addr port", base_addr, 32'hA5A5_0004);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule